// File: doc/BRIEF.md
# Synchronous Multi-Ratio Clock Divider Bank

This block takes one fast source clock and derives nine clock outputs from it, arranged in four groups of one, one, two and five bits, plus a separate feedback clock. Each group has its own select pin that picks one of two even ratios. The feedback clock has its own select that picks one of two larger ratios. Every output is a power-of-two division of the same free-running phase counter, so all outputs have exactly 50% duty. Wherever two outputs both have a rising edge, those edges fall on the same source edge.

A bypass select replaces the internal source with an external test clock, which then drives the dividers. An active-high master reset clears the dividers and holds every output low. While it is asserted, a set of per-output enable flags drops to zero to model a high-impedance state. A change on any select pin is held back until the counter wraps. That wrap is the common rising edge of the slowest ratio, so no output ever emits a shortened pulse.

Top module: `clkdiv_bank`

## Requirements
- R1: Group A (`q_a`) divides the divider clock by 2 when `sel_a` is 0 and by 4 when `sel_a` is 1.
- R2: Groups B, C and D (`q_b`, `q_c`, `q_d`) each divide by 4 when their own select is 0 and by 8 when it is 1. Each group follows only its own select.
- R3: Both bits of `q_c` are always identical, and all five bits of `q_d` are always identical.
- R4: `fb_clk` divides by 8 when `fb_sel` is 1 and by 16 when `fb_sel` is 0.
- R5: Every output is high for exactly half of its period, measured in divider-clock cycles.
- R6: Any output that rises does so on a divider-clock edge on which every faster-or-equal output also rises. The phase of each output equals (divider edges since reset release, modulo its ratio) being below half the ratio.
- R7: `out_en` is all zeros while `rst_dis` is 1 and all ones while it is 0.
- R8: While `rst_dis` is 1, all outputs and `fb_clk` are low at once, without waiting for a clock edge.
- R9: On the first divider-clock rising edge after `rst_dis` falls, all nine outputs and `fb_clk` go high together.
- R10: A new select value takes effect only on the divider edge where the phase counter wraps to zero (every 16 edges after reset release). Before that edge the old ratio continues unchanged.
- R11: When `pll_on` is 0, the dividers count `test_clk` edges instead of `src_clk` edges. When `pll_on` is 1, they count `src_clk` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Fast internal source clock |
| test_clk | input | 1 | External clock used in bypass |
| pll_on | input | 1 | 1 selects src_clk, 0 selects test_clk as divider clock |
| rst_dis | input | 1 | Active-high master reset and output disable |
| sel_a | input | 1 | Group A ratio: 0 = /2, 1 = /4 |
| sel_b | input | 1 | Group B ratio: 0 = /4, 1 = /8 |
| sel_c | input | 1 | Group C ratio: 0 = /4, 1 = /8 |
| sel_d | input | 1 | Group D ratio: 0 = /4, 1 = /8 |
| fb_sel | input | 1 | Feedback ratio: 1 = /8, 0 = /16 |
| q_a | output | 1 | Group A clock |
| q_b | output | 1 | Group B clock |
| q_c | output | NC (2) | Group C clocks |
| q_d | output | ND (5) | Group D clocks |
| fb_clk | output | 1 | Feedback clock |
| out_en | output | 1+1+NC+ND (9) | Per-output enable flags: bit 0 q_a, bit 1 q_b, then q_c, then q_d |

## Verification
Some properties are checked on every divider-clock edge:
- rising edges stay aligned between the slow outputs and the faster ones;
- the bits inside groups C and D stay identical;
- the feedback and group B clocks never produce a one-cycle high pulse;
- everything is quiet while reset is asserted.

The exact period and high time of each output cannot be seen by these per-cycle properties. Nor can the placement of a ratio change at the counter wrap, or the switch to the test clock in bypass. The bench shows these by sweeping every group-select combination under both feedback ratios and comparing sampled waveforms with phases it computes itself.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   // A ratio is legal when it is an even power of two that the phase counter can reach.
   function automatic bit log_ok(input int lg, input int cw);
      return (lg >= 1) && (lg <= cw);
   endfunction

endpackage

// File: rtl/clkdiv_phase.sv
module clkdiv_phase #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst,
   output logic [CW-1:0] cnt,
   output logic          wrap
);

   generate
      if (CW < 1) begin : g_bad_cw
         $error("clkdiv_phase: CW must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or posedge rst) begin
      if (rst) cnt <= '0;
      else     cnt <= cnt + 1'b1;
   end

   // Common rising edge of every ratio up to 2**CW.
   assign wrap = (cnt == '0);

endmodule

// File: rtl/clkdiv_tap.sv
module clkdiv_tap
   import clkdiv_pkg::*;
#(
   parameter int CW   = 4,
   parameter int LOG0 = 1,
   parameter int LOG1 = 2,
   parameter int FAN  = 1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [CW-1:0]  cnt,
   input  logic           wrap,
   input  logic           sel,
   output logic [FAN-1:0] q
);

   localparam int BIT0 = LOG0 - 1;
   localparam int BIT1 = LOG1 - 1;

   generate
      if (!log_ok(LOG0, CW) || !log_ok(LOG1, CW)) begin : g_bad_log
         $error("clkdiv_tap: ratio exponents must lie in 1..CW");
      end
      if (FAN < 1) begin : g_bad_fan
         $error("clkdiv_tap: FAN must be at least 1");
      end
   endgenerate

   logic sel_hold;
   logic sel_use;
   logic hi_phase;

   assign sel_use  = wrap ? sel : sel_hold;
   assign hi_phase = sel_use ? ~cnt[BIT1] : ~cnt[BIT0];

   always_ff @(posedge clk or posedge rst) begin
      if (rst)       sel_hold <= 1'b0;
      else if (wrap) sel_hold <= sel;
   end

   genvar gi;
   generate
      for (gi = 0; gi < FAN; gi++) begin : g_out
         always_ff @(posedge clk or posedge rst) begin
            if (rst) q[gi] <= 1'b0;
            else     q[gi] <= hi_phase;
         end
      end
   endgenerate

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
   parameter int CW       = 4,
   parameter int NC       = 2,
   parameter int ND       = 5,
   parameter int A_LOG0   = 1,
   parameter int A_LOG1   = 2,
   parameter int BCD_LOG0 = 2,
   parameter int BCD_LOG1 = 3,
   parameter int FB_LOG0  = 4,
   parameter int FB_LOG1  = 3,
   localparam int NOUT    = 2 + NC + ND
) (
   input  logic            src_clk,
   input  logic            test_clk,
   input  logic            pll_on,
   input  logic            rst_dis,
   input  logic            sel_a,
   input  logic            sel_b,
   input  logic            sel_c,
   input  logic            sel_d,
   input  logic            fb_sel,
   output logic            q_a,
   output logic            q_b,
   output logic [NC-1:0]   q_c,
   output logic [ND-1:0]   q_d,
   output logic            fb_clk,
   output logic [NOUT-1:0] out_en
);

   generate
      if (NC < 1 || ND < 1) begin : g_bad_fan
         $error("clkdiv_bank: group widths must be at least 1");
      end
      if (FB_LOG0 != CW && FB_LOG1 != CW) begin : g_bad_wrap
         $error("clkdiv_bank: slowest feedback ratio must equal the counter span");
      end
   endgenerate

   logic          div_clk;
   logic [CW-1:0] cnt;
   logic          wrap;

   assign div_clk = pll_on ? src_clk : test_clk;

   clkdiv_phase #(.CW(CW)) u_phase (
      .clk (div_clk), .rst (rst_dis), .cnt (cnt), .wrap (wrap)
   );

   clkdiv_tap #(.CW(CW), .LOG0(A_LOG0), .LOG1(A_LOG1), .FAN(1)) u_tap_a (
      .clk (div_clk), .rst (rst_dis), .cnt (cnt), .wrap (wrap), .sel (sel_a), .q (q_a)
   );

   clkdiv_tap #(.CW(CW), .LOG0(BCD_LOG0), .LOG1(BCD_LOG1), .FAN(1)) u_tap_b (
      .clk (div_clk), .rst (rst_dis), .cnt (cnt), .wrap (wrap), .sel (sel_b), .q (q_b)
   );

   clkdiv_tap #(.CW(CW), .LOG0(BCD_LOG0), .LOG1(BCD_LOG1), .FAN(NC)) u_tap_c (
      .clk (div_clk), .rst (rst_dis), .cnt (cnt), .wrap (wrap), .sel (sel_c), .q (q_c)
   );

   clkdiv_tap #(.CW(CW), .LOG0(BCD_LOG0), .LOG1(BCD_LOG1), .FAN(ND)) u_tap_d (
      .clk (div_clk), .rst (rst_dis), .cnt (cnt), .wrap (wrap), .sel (sel_d), .q (q_d)
   );

   clkdiv_tap #(.CW(CW), .LOG0(FB_LOG0), .LOG1(FB_LOG1), .FAN(1)) u_tap_fb (
      .clk (div_clk), .rst (rst_dis), .cnt (cnt), .wrap (wrap), .sel (fb_sel), .q (fb_clk)
   );

   assign out_en = {NOUT{~rst_dis}};

endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
   parameter int NC   = 2,
   parameter int ND   = 5,
   parameter int NOUT = 2 + NC + ND
) (
   input logic            clk,
   input logic            rst,
   input logic            q_a,
   input logic            q_b,
   input logic [NC-1:0]   q_c,
   input logic [ND-1:0]   q_d,
   input logic            fb_clk,
   input logic [NOUT-1:0] out_en
);

   // R6
   rise_align_b_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(q_b) |-> $rose(q_a));

   // R6
   rise_align_cd_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(q_c[0]) || $rose(q_d[0])) |-> $rose(q_a));

   // R6
   rise_align_fb_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(fb_clk) |-> ($rose(q_a) && $rose(q_b) && $rose(q_c[0]) && $rose(q_d[0])));

   // R3
   group_c_eq_chk: assert property (@(posedge clk) disable iff (rst)
      ($countones(q_c) == 0) || ($countones(q_c) == NC));

   // R3
   group_d_eq_chk: assert property (@(posedge clk) disable iff (rst)
      ($countones(q_d) == 0) || ($countones(q_d) == ND));

   // R5
   fb_no_runt_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(fb_clk) |=> fb_clk);

   // R5
   b_no_runt_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(q_b) |=> q_b);

   // R8
   dis_quiet_chk: assert property (@(posedge clk)
      rst |-> (!q_a && !q_b && (q_c == '0) && (q_d == '0) && !fb_clk && (out_en == '0)));

endmodule

bind clkdiv_bank clkdiv_bank_chk #(.NC(NC), .ND(ND)) u_chk (
   .clk    (div_clk),
   .rst    (rst_dis),
   .q_a    (q_a),
   .q_b    (q_b),
   .q_c    (q_c),
   .q_d    (q_d),
   .fb_clk (fb_clk),
   .out_en (out_en)
);

// File: tb/tb_clkdiv_bank.sv
module tb_clkdiv_bank;

   localparam int SRC_PER  = 10;
   localparam int TEST_PER = 14;
   localparam int NSMP     = 48;

   logic       src_clk  = 1'b0;
   logic       test_clk = 1'b0;
   logic       pll_on   = 1'b1;
   logic       rst_dis  = 1'b1;
   logic       sel_a = 1'b0, sel_b = 1'b0, sel_c = 1'b0, sel_d = 1'b0;
   logic       fb_sel = 1'b0;
   logic       q_a, q_b, fb_clk;
   logic [1:0] q_c;
   logic [4:0] q_d;
   logic [8:0] out_en;

   int n_run  = 0;
   int n_fail = 0;

   clkdiv_bank dut (
      .src_clk (src_clk), .test_clk (test_clk), .pll_on (pll_on), .rst_dis (rst_dis),
      .sel_a (sel_a), .sel_b (sel_b), .sel_c (sel_c), .sel_d (sel_d), .fb_sel (fb_sel),
      .q_a (q_a), .q_b (q_b), .q_c (q_c), .q_d (q_d), .fb_clk (fb_clk), .out_en (out_en)
   );

   always #(SRC_PER/2)  src_clk  = ~src_clk;
   always #(TEST_PER/2) test_clk = ~test_clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [9:0] snap();
      return {fb_clk, q_d, q_c, q_b, q_a};
   endfunction

   initial begin
      #(SRC_PER * 150000);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [9:0] smp [NSMP];

      // R8 R7: reset state
      repeat (3) @(negedge src_clk);
      chk(snap() == '0, "R8 outputs low in reset", int'(snap()), 0);
      chk(out_en == '0, "R7 enables off in reset", int'(out_en), 0);

      // R9 R7: release, first edge brings all high
      rst_dis = 1'b0;
      @(negedge src_clk);
      chk(snap() == 10'h3FF, "R9 all high on first edge", int'(snap()), 'h3FF);
      chk(out_en == 9'h1FF, "R7 enables on", int'(out_en), 'h1FF);

      // R10: sel_a change held until wrap
      begin
         int bad = 0;
         int first_j = -1;
         for (int j = 1; j < 32; j++) begin
            if (j == 3) sel_a = 1'b1;
            @(negedge src_clk);
            if (q_a != ((j < 16) ? ((j % 2) == 0) : ((j % 4) < 2))) begin
               bad++;
               if (first_j < 0) first_j = j;
            end
         end
         chk(bad == 0, "R10 ratio switch at wrap only", first_j, -1);
      end

      // R1 R2 R3 R4 R5 R6: full sweep
      for (int fbv = 0; fbv < 2; fbv++) begin
         for (int combo = 0; combo < 16; combo++) begin
            int na, nb, nc, nd, nf, i0, bad_r3;
            sel_a  = combo[3];
            sel_b  = combo[2];
            sel_c  = combo[1];
            sel_d  = combo[0];
            fb_sel = fbv[0];
            repeat (40) @(negedge src_clk);
            for (int i = 0; i < NSMP; i++) begin
               smp[i] = snap();
               @(negedge src_clk);
            end
            na = sel_a ? 4 : 2;
            nb = sel_b ? 8 : 4;
            nc = sel_c ? 8 : 4;
            nd = sel_d ? 8 : 4;
            nf = fb_sel ? 8 : 16;
            i0 = -1;
            for (int i = 1; i < 18; i++)
               if (i0 < 0 && smp[i][9] && !smp[i-1][9]) i0 = i;
            chk(i0 > 0, "R6 feedback rise found", i0, 1);
            if (i0 < 0) i0 = 0;
            for (int b = 0; b < 10; b++) begin
               int n, bad, first_i;
               string req;
               if (b == 0)      begin n = na; req = "R1 R5 R6 group A"; end
               else if (b == 1) begin n = nb; req = "R2 R5 R6 group B"; end
               else if (b < 4)  begin n = nc; req = "R2 R5 R6 group C"; end
               else if (b < 9)  begin n = nd; req = "R2 R5 R6 group D"; end
               else             begin n = nf; req = "R4 R5 R6 feedback"; end
               bad = 0;
               first_i = -1;
               for (int i = 0; i < NSMP; i++) begin
                  if (smp[i][b] != (((i - i0 + NSMP) % n) < (n / 2))) begin
                     bad++;
                     if (first_i < 0) first_i = i;
                  end
               end
               chk(bad == 0, req, first_i, -1);
            end
            bad_r3 = 0;
            for (int i = 0; i < NSMP; i++) begin
               if (smp[i][3] != smp[i][2]) bad_r3++;
               if (smp[i][8:4] != {5{smp[i][4]}}) bad_r3++;
            end
            chk(bad_r3 == 0, "R3 group bits identical", bad_r3, 0);
         end
      end

      // R8 R7: asynchronous disable mid-run
      #3;
      rst_dis = 1'b1;
      #1;
      chk(snap() == '0, "R8 async clear", int'(snap()), 0);
      chk(out_en == '0, "R7 disable mid-run", int'(out_en), 0);

      // R11: bypass with test clock
      sel_a = 1'b0; sel_b = 1'b0; sel_c = 1'b0; sel_d = 1'b0; fb_sel = 1'b0;
      pll_on = 1'b0;
      repeat (2) @(negedge test_clk);
      rst_dis = 1'b0;
      begin
         int bad = 0;
         int first_j = -1;
         for (int j = 0; j < 16; j++) begin
            @(negedge test_clk);
            if (q_a != ((j % 2) == 0) || q_d[0] != ((j % 4) < 2)) begin
               bad++;
               if (first_j < 0) first_j = j;
            end
         end
         chk(bad == 0, "R11 bypass counts test clock", first_j, -1);
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule